// File: doc/BRIEF.md
# Decimal Record Tape Transfer Controller

This block moves text characters between a decimal digit store and a paper tape reader or punch. Each stored digit is six bits wide: an odd-parity check bit at the top, then a flag bit, then four BCD bits weighted 8, 4, 2 and 1. The store is reached one even/odd digit pair per access, and one pair holds one character. The zone digit sits in the even position and the numeric digit in the odd position.

A transfer starts with a one-cycle `start` pulse. The pulse carries a direction and a five-digit BCD start address. In read direction, every character the reader hands over becomes one parity-encoded pair in the store, and the transfer ends after it stores a character whose numeric digit is the record mark. In punch direction, pairs are fetched in address order, checked for parity and sent to the punch. When a pair holds the record mark, the block sends a fixed end-of-line code in its place and stops. A parity failure stops the transfer at once. After each pair the address steps up by two in decimal and wraps to zero at the end of the configured store.

Top module: `dtape_xfer`

## Requirements
- R1: Every written digit is {check, flag, 8, 4, 2, 1} with flag 0 and the check bit chosen so the six bits hold an odd number of ones. The zone nibble (rd_char[7:4]) goes to mem_wdata[11:6] and the numeric nibble (rd_char[3:0]) goes to mem_wdata[5:0].
- R2: In read direction, each accepted character (rd_valid and rd_ready high at a clock edge) writes exactly one pair at the current address, and the address then advances by two.
- R3: In read direction, a character whose numeric nibble is 1010 (record mark) is stored like any other. After it, rd_ready falls, busy falls and done is high for exactly one cycle.
- R4: In punch direction, pairs are read in address order and each is offered as pun_char = {even digit BCD, odd digit BCD}. pun_char is held stable with pun_valid high until pun_ready is seen.
- R5: In punch direction, a pair whose odd digit BCD is 1010 is not punched. The code EOL_CODE is offered instead, and after it is accepted the transfer ends with a one-cycle done pulse.
- R6: In punch direction, a pair in which either digit has even parity ends the transfer with err high and a done pulse. No character of that pair or any later pair is offered. err stays high until the next start.
- R7: The address advances in BCD with decimal carry (00008 to 00010, 00098 to 00100).
- R8: When the address plus two would reach MEM_DIGITS, the next address is 00000.
- R9: Bit 0 of the start address is ignored, so every access uses an even address.
- R10: After reset, busy, done, err, mem_req, rd_ready and pun_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| mode_punch | input | 1 | 1 = store to punch, 0 = reader to store |
| start_addr | input | 4*ADDR_DIGITS | BCD start address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Parity failure seen in last punch transfer |
| mem_req | output | 1 | Store access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 4*ADDR_DIGITS | BCD address of the even digit |
| mem_wdata | output | 12 | Pair to write, even digit in [11:6] |
| mem_rdata | input | 12 | Pair read, valid the cycle after the request |
| rd_valid | input | 1 | Reader offers a character |
| rd_char | input | 8 | Reader character {zone, numeric} |
| rd_ready | output | 1 | Block accepts a reader character |
| pun_valid | output | 1 | Character offered to the punch |
| pun_char | output | 8 | Punch character {zone, numeric} |
| pun_ready | input | 1 | Punch accepts the character |

## Verification
A wrong address register appears at once on mem_addr during the next write or fetch. A wrong decimal carry or wrap puts a pair at the wrong location, so the bench finds it when it reads back the written addresses. A stuck or misrouted sequencing state shows in the same transfer: characters are dropped or repeated on pun_char, the end-of-line code is missing, or done never arrives within a few cycles of the record mark. A parity error that is missed or raised by mistake shows in err and in how many characters were punched before done.

// File: rtl/dtape_pkg.sv
package dtape_pkg;
  localparam int DIGIT_W = 6;
  localparam int PAIR_W  = 2 * DIGIT_W;
  localparam logic [3:0] BCD_RECMARK = 4'b1010;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_PREQ,
    ST_PCHK,
    ST_PSEND
  } xfer_st_t;
endpackage

// File: rtl/dtape_digit_enc.sv
module dtape_digit_enc
  import dtape_pkg::*;
(
  input  logic [3:0] bcd_i,
  input  logic       flag_i,
  output digit_t     digit_o
);
  // check bit makes the total count of ones odd
  assign digit_o = {~^{flag_i, bcd_i}, flag_i, bcd_i};
endmodule

// File: rtl/dtape_pair_chk.sv
module dtape_pair_chk
  import dtape_pkg::*;
(
  input  logic [PAIR_W-1:0] pair_i,
  output logic              par_ok_o,
  output logic              rec_mark_o
);
  logic [1:0] dig_ok;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_dig
      assign dig_ok[g] = ^pair_i[g*DIGIT_W +: DIGIT_W];
    end
  endgenerate

  assign par_ok_o   = &dig_ok;
  assign rec_mark_o = (pair_i[3:0] == BCD_RECMARK);
endmodule

// File: rtl/dtape_addr_step.sv
module dtape_addr_step #(
  parameter int ADDR_DIGITS = 5,
  parameter int MEM_DIGITS  = 20000
) (
  input  logic [4*ADDR_DIGITS-1:0] addr_i,
  output logic [4*ADDR_DIGITS-1:0] addr_o
);
  localparam int AW = 4 * ADDR_DIGITS;

  logic [ADDR_DIGITS:0] carry;
  logic [AW-1:0]        sum;
  logic [31:0]          value;
  logic                 wrap;

  assign carry[0] = 1'b0;

  generate
    for (genvar g = 0; g < ADDR_DIGITS; g++) begin : g_dig
      logic [4:0] raw;
      logic [4:0] adj;
      assign raw          = {1'b0, addr_i[4*g +: 4]} + ((g == 0) ? 5'd2 : 5'd0)
                            + {4'b0000, carry[g]};
      assign adj          = raw - 5'd10;
      assign carry[g+1]   = (raw > 5'd9);
      assign sum[4*g +: 4] = carry[g+1] ? adj[3:0] : raw[3:0];
    end
  endgenerate

  always_comb begin
    value = 32'd0;
    for (int i = ADDR_DIGITS - 1; i >= 0; i--) begin
      value = value * 32'd10 + {28'd0, addr_i[4*i +: 4]};
    end
  end

  assign wrap   = ((value + 32'd2) >= 32'(MEM_DIGITS)) || carry[ADDR_DIGITS];
  assign addr_o = wrap ? '0 : sum;
endmodule

// File: rtl/dtape_xfer.sv
module dtape_xfer
  import dtape_pkg::*;
#(
  parameter int         ADDR_DIGITS = 5,
  parameter int         MEM_DIGITS  = 20000,
  parameter logic [7:0] EOL_CODE    = 8'hEF,
  localparam int        AW          = 4 * ADDR_DIGITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_punch,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [11:0]   mem_wdata,
  input  logic [11:0]   mem_rdata,
  input  logic          rd_valid,
  input  logic [7:0]    rd_char,
  output logic          rd_ready,
  output logic          pun_valid,
  output logic [7:0]    pun_char,
  input  logic          pun_ready
);
  xfer_st_t      st_q, st_d;
  logic [AW-1:0] addr_q, addr_d, addr_nx;
  logic          addr_en;
  logic [7:0]    pun_q, pun_d;
  logic          last_q, last_d;
  logic          pun_en;
  logic          done_q, done_d;
  logic          err_q, err_d;
  digit_t        zone_dig, num_dig;
  logic          par_ok, rec_mark;

  dtape_addr_step #(
    .ADDR_DIGITS(ADDR_DIGITS),
    .MEM_DIGITS (MEM_DIGITS)
  ) u_step (
    .addr_i(addr_q),
    .addr_o(addr_nx)
  );

  dtape_digit_enc u_enc_zone (
    .bcd_i  (rd_char[7:4]),
    .flag_i (1'b0),
    .digit_o(zone_dig)
  );

  dtape_digit_enc u_enc_num (
    .bcd_i  (rd_char[3:0]),
    .flag_i (1'b0),
    .digit_o(num_dig)
  );

  dtape_pair_chk u_chk_pair (
    .pair_i    (mem_rdata),
    .par_ok_o  (par_ok),
    .rec_mark_o(rec_mark)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    pun_d   = pun_q;
    last_d  = last_q;
    pun_en  = 1'b0;
    done_d  = 1'b0;
    err_d   = err_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          err_d   = 1'b0;
          addr_d  = start_addr & ~{{(AW-1){1'b0}}, 1'b1};
          addr_en = 1'b1;
          st_d    = mode_punch ? ST_PREQ : ST_READ;
        end
      end
      ST_READ: begin
        if (rd_valid) begin
          addr_d  = addr_nx;
          addr_en = 1'b1;
          if (rd_char[3:0] == BCD_RECMARK) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
      end
      ST_PREQ: st_d = ST_PCHK;
      ST_PCHK: begin
        if (!par_ok) begin
          err_d  = 1'b1;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          pun_d  = rec_mark ? EOL_CODE : {mem_rdata[9:6], mem_rdata[3:0]};
          last_d = rec_mark;
          pun_en = 1'b1;
          st_d   = ST_PSEND;
        end
      end
      ST_PSEND: begin
        if (pun_ready) begin
          if (last_q) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            addr_d  = addr_nx;
            addr_en = 1'b1;
            st_d    = ST_PREQ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pun_q  <= '0;
      last_q <= 1'b0;
    end else if (pun_en) begin
      pun_q  <= pun_d;
      last_q <= last_d;
    end
  end

  // outputs
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign rd_ready  = (st_q == ST_READ);
  assign mem_we    = (st_q == ST_READ) && rd_valid;
  assign mem_req   = mem_we || (st_q == ST_PREQ);
  assign mem_addr  = addr_q;
  assign mem_wdata = {zone_dig, num_dig};
  assign pun_valid = (st_q == ST_PSEND);
  assign pun_char  = pun_q;
endmodule

// File: rtl/dtape_xfer_chk.sv
module dtape_xfer_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          err,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [11:0]   mem_wdata,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          pun_valid,
  input logic [7:0]    pun_char,
  input logic          pun_ready
);
  p_wdata_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((^mem_wdata[11:6]) && (^mem_wdata[5:0]) && !mem_wdata[10] && !mem_wdata[4]));

  p_write_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && rd_valid && rd_ready));

  p_one_direction_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ready && pun_valid));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_punch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pun_valid && !pun_ready) |=> (pun_valid && $stable(pun_char)));

  p_silent_after_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !pun_valid);

  p_even_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);
endmodule

bind dtape_xfer dtape_xfer_chk #(.AW(AW)) u_xfer_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .done     (done),
  .err      (err),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .pun_valid(pun_valid),
  .pun_char (pun_char),
  .pun_ready(pun_ready)
);

// File: tb/dtape_xfer_tb.sv
module dtape_xfer_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int         MEMD = 200;
  localparam int         NPR  = MEMD / 2;
  localparam logic [7:0] EOL  = 8'hEF;

  logic        clk, rst_n, start, mode_punch;
  logic [19:0] start_addr;
  logic        busy, done, err, mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [11:0] mem_wdata, mem_rdata;
  logic        rd_valid, rd_ready, pun_valid, pun_ready;
  logic [7:0]  rd_char, pun_char;

  int nchk = 0, nfail = 0;
  int nw = 0, np = 0, cyc = 0;
  bit stall = 0;
  logic [11:0] mem  [0:NPR-1];
  logic [19:0] wlog [0:255];
  logic [7:0]  plog [0:255];

  dtape_xfer #(.ADDR_DIGITS(5), .MEM_DIGITS(MEMD), .EOL_CODE(EOL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_punch(mode_punch),
    .start_addr(start_addr), .busy(busy), .done(done), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rd_valid(rd_valid),
    .rd_char(rd_char), .rd_ready(rd_ready), .pun_valid(pun_valid),
    .pun_char(pun_char), .pun_ready(pun_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [19:0] i2b(int v);
    logic [19:0] r;
    for (int k = 0; k < 5; k++) begin
      r[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int b2i(logic [19:0] a);
    int v = 0;
    for (int k = 4; k >= 0; k--) v = v * 10 + int'(a[4*k +: 4]);
    return v;
  endfunction

  function automatic logic [5:0] enc(logic [3:0] b);
    return {~^b, 1'b0, b};
  endfunction

  function automatic int nxt(int a);
    return (a + 2 >= MEMD) ? 0 : a + 2;
  endfunction

  // store and device models, capturing at the clock edge
  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      mem[(b2i(mem_addr) / 2) % NPR] <= mem_wdata;
      wlog[nw % 256] <= mem_addr;
      nw <= nw + 1;
    end
    if (mem_req && !mem_we) mem_rdata <= mem[(b2i(mem_addr) / 2) % NPR];
    if (pun_valid && pun_ready) begin
      plog[np % 256] <= pun_char;
      np <= np + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    pun_ready <= stall ? (cyc % 3 == 0) : 1'b1;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(done, req, {31'd0, done}, 1);
    @(negedge clk);
    chk(!done && !busy && !rd_ready && !pun_valid, req, {28'd0, done, busy, rd_ready, pun_valid}, 0);
  endtask

  task automatic begin_xfer(bit p, int sa);
    @(negedge clk);
    mode_punch = p;
    start_addr = i2b(sa);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_char(logic [7:0] c);
    rd_valid = 1'b1;
    rd_char  = c;
    while (!rd_ready) @(negedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  // read direction: n characters of zone z followed by a record mark
  task automatic run_read(int sa, int z);
    int base = nw;
    int a = sa & ~1;
    logic [7:0] c;
    begin_xfer(1'b0, sa);
    for (int i = 0; i <= 10; i++) begin
      c = (i == 10) ? 8'h0A : {4'(z), 4'(i)};
      send_char(c);
    end
    wait_done("R3 read end");
    chk(nw - base == 11, "R2 write count", 32'(nw - base), 11);
    for (int i = 0; i <= 10; i++) begin
      c = (i == 10) ? 8'h0A : {4'(z), 4'(i)};
      chk(wlog[(base + i) % 256] == i2b(a), "R2 R7 R8 R9 address", {12'd0, wlog[(base + i) % 256]}, {12'd0, i2b(a)});
      chk(mem[a / 2] == {enc(c[7:4]), enc(c[3:0])}, "R1 pair encoding", {20'd0, mem[a / 2]}, {20'd0, enc(c[7:4]), enc(c[3:0])});
      a = nxt(a);
    end
  endtask

  // punch direction: n characters, record mark, optional bad pair
  task automatic run_punch(int sa, int n, int seed, int bad, bit st);
    int base = np;
    int a = sa;
    int expn;
    logic [3:0] z, d;
    logic [7:0] e;
    stall = st;
    for (int i = 0; i <= n; i++) begin
      z = (i == n) ? 4'd0 : 4'((i * 3 + seed) % 10);
      d = (i == n) ? 4'hA : 4'((i * 7 + seed) % 10);
      mem[a / 2] = {enc(z), enc(d)};
      if (i == bad) mem[a / 2][11] = ~mem[a / 2][11];
      a = nxt(a);
    end
    begin_xfer(1'b1, sa);
    wait_done("R5 R6 punch end");
    expn = (bad >= 0) ? bad : n + 1;
    chk(np - base == expn, "R5 R6 punch count", 32'(np - base), 32'(expn));
    chk(err == (bad >= 0), "R6 err flag", {31'd0, err}, {31'd0, bad >= 0});
    for (int i = 0; i < expn && i < np - base; i++) begin
      e = (i == n) ? EOL : {4'((i * 3 + seed) % 10), 4'((i * 7 + seed) % 10)};
      chk(plog[(base + i) % 256] == e, (i == n) ? "R5 end-of-line" : "R4 punch char",
          {24'd0, plog[(base + i) % 256]}, {24'd0, e});
    end
    stall = 0;
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode_punch = 1'b0; start_addr = '0;
    rd_valid = 1'b0; rd_char = '0;
    for (int i = 0; i < NPR; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !mem_req && !rd_ready && !pun_valid, "R10 reset",
        {26'd0, busy, done, err, mem_req, rd_ready, pun_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // every zone/numeric combination, varied (some odd, wrapping, carrying) starts
    for (int z = 0; z < 10; z++) run_read((z * 37) % MEMD, z);
    run_read(96, 3);       // R7: 98 -> 100
    run_read(191, 9);      // R8 R9: odd start, wraps past 198
    run_punch(10, 6, 1, -1, 1'b0);
    run_punch(40, 12, 4, -1, 1'b1);  // R4 hold under back-pressure
    run_punch(194, 5, 7, -1, 1'b1);  // R8 wrap while punching
    run_punch(120, 8, 2, 3, 1'b0);   // R6 parity abort
    run_punch(120, 8, 5, 0, 1'b1);   // R6 abort on first pair
    run_punch(60, 4, 9, -1, 1'b0);   // R6 err cleared by new start
    run_punch(88, 0, 0, -1, 1'b0);   // R5 record mark only
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule